// File: doc/BRIEF.md
# NAND Flash Instruction Sequencer

This block carries out a short program of NAND flash bus operations. Before a run, the host sets up five things on the block's input ports:

- an instruction word that holds eight 4-bit opcode slots;
- a word of four command bytes;
- a page address and a column address;
- a spare-area flag and a page-size mode;
- a byte count.

A one-cycle `start` pulse latches all of these inputs. The sequencer then steps through the opcode slots. For each opcode it drives command, address and data cycles on the flash pins, or it waits for the ready/busy line. Data moves between the flash bus and an internal page buffer. The host fills this buffer before a program run and reads it back after a read run.

The page buffer is split into eight units. The page address and the page-size mode select which unit a transfer uses. When the run ends, the block sets a completion flag. If the flash stays busy for too long, it sets a timeout flag instead. Both flags are cleared by writing 1 to them.

Top module: `nand_seq`

## Requirements
- R1: Slots run from slot 0 (instr[3:0]) upward, four bits per slot. The program ends at the first slot holding code 0, 14 or 15, or after slot 7 has run. Opcode codes are: 0 end, 1 column address, 2 page address, 3 single address byte, 4..7 command n without wait, 8..11 command n with wait, 12 write data, 13 wait then read data.
- R2: A command opcode with index n (code 4+n or 8+n) sends cmds[8n+7:8n] as one write cycle with CLE high. The codes 8..11 then wait for nf_rb_n high before the next slot. The codes 4..7 go on without waiting, even while nf_rb_n is low.
- R3: Every address byte is one write cycle with ALE high. Code 1 sends col[7:0] then col[15:8] in large-page mode, and only col[7:0] in small-page mode. Code 2 sends page[7:0] then page[15:8]. Code 3 sends col[7:0]. CLE and ALE are never high together.
- R4: The data length of codes 12 and 13 is `count` bytes when `count` is nonzero. When `count` is 0, the length is main plus spare: 128+16 = 144 bytes in small-page mode and 512+64 = 576 bytes in large-page mode (default parameters).
- R5: Transfers begin at buffer address base + col + S. The base is page[2:0]×256 in small-page mode and page[0]×1024 in large-page mode. S is the main-area size (128 small, 512 large) when `spare` is 1, and 0 otherwise.
- R6: Code 13 waits for nf_rb_n high, then reads the bytes into consecutive buffer addresses. Code 12 sends bytes from consecutive buffer addresses as data write cycles, with CLE and ALE low.
- R7: Each WE# or RE# strobe is low for exactly STRB (2) clocks. Written data is on nf_io_out from one clock before WE# falls until it rises. WE# and RE# are never low together. CE# is low, and the other strobes are active, only while busy.
- R8: When a program ends, busy drops and done_flag is set. If nf_rb_n stays low for TMO (64) clocks during a wait, the program is abandoned: busy drops, tmo_flag is set and done_flag is not set.
- R9: stat_clr[0] clears done_flag and stat_clr[1] clears tmo_flag. A clear in the same cycle as a set loses, so the flag stays set.
- R10: A start pulse while busy is ignored, and the running program continues unchanged.
- R11: hb_rdata returns the buffer byte at hb_addr one clock later. Writes through hb_we take effect only while not busy.
- R12: After reset, busy, done_flag and tmo_flag are 0, CE#, WE# and RE# are high, and CLE and ALE are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run trigger pulse |
| instr | input | 32 | Eight opcode slots, slot 0 in the low nibble |
| cmds | input | 32 | Command bytes 0..3, byte 0 in the low byte |
| page | input | 16 | Page (row) address |
| col | input | 16 | Column address |
| spare | input | 1 | Offset the buffer start into the spare area |
| large_pg | input | 1 | 1: large-page mode, 0: small-page mode |
| count | input | 16 | Data byte count, 0 selects full page plus spare |
| stat_clr | input | 2 | Write-1-to-clear: bit 0 done, bit 1 timeout |
| busy | output | 1 | Program running |
| done_flag | output | 1 | Completion flag |
| tmo_flag | output | 1 | Ready-wait timeout flag |
| hb_we | input | 1 | Host buffer write enable |
| hb_addr | input | 11 | Host buffer byte address |
| hb_wdata | input | 8 | Host buffer write data |
| hb_rdata | output | 8 | Host buffer read data (one-clock latency) |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Flash I/O bus output value |
| nf_io_oe | output | 1 | Flash I/O bus output enable |
| nf_io_in | input | 8 | Flash I/O bus input value |
| nf_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
Setting the done flag at the end of a program can fall in the same clock as a software clear of that flag. To provoke this, the bench holds stat_clr[0] high for a whole short command program. The flag must then be seen high for exactly one sampled cycle, on the edge where busy drops, and must read 0 afterwards. A start pulse that arrives in the middle of a long full-page read is also checked: the count of read strobes must still equal the full page plus spare.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int UNIT     = 256,
  parameter int SP_MAIN  = 128,
  parameter int SP_SPARE = 16,
  parameter int LP_MAIN  = 512,
  parameter int LP_SPARE = 64,
  parameter int STRB     = 2,
  parameter int TMO      = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [31:0]                   instr,
  input  logic [31:0]                   cmds,
  input  logic [15:0]                   page,
  input  logic [15:0]                   col,
  input  logic                          spare,
  input  logic                          large_pg,
  input  logic [15:0]                   count,
  input  logic [1:0]                    stat_clr,
  output logic                          busy,
  output logic                          done_flag,
  output logic                          tmo_flag,
  input  logic                          hb_we,
  input  logic [$clog2(8*UNIT)-1:0]     hb_addr,
  input  logic [7:0]                    hb_wdata,
  output logic [7:0]                    hb_rdata,
  output logic                          nf_ce_n,
  output logic                          nf_cle,
  output logic                          nf_ale,
  output logic                          nf_we_n,
  output logic                          nf_re_n,
  output logic [7:0]                    nf_io_out,
  output logic                          nf_io_oe,
  input  logic [7:0]                    nf_io_in,
  input  logic                          nf_rb_n
);
  localparam int BUF = 8 * UNIT;
  localparam int AW  = $clog2(BUF);
  localparam int UW  = $clog2(UNIT);
  localparam int TW  = $clog2(STRB + 2);
  localparam int WW  = $clog2(TMO + 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_WAIT} st_t;

  st_t            st;
  logic [3:0]     slot, op;
  logic [31:0]    ins_q, cmd_q;
  logic [15:0]    page_q, col_q, tot, nleft;
  logic           lp_q, bidx;
  logic [TW-1:0]  tcnt;
  logic [WW-1:0]  wcnt;
  logic [AW-1:0]  ptr;
  logic [7:0]     mem [BUF];

  logic is_cm, is_cw, is_cmd, is_addr, is_wb, is_rd, strobe_lo, cap;
  logic [3:0]    nxt_op;
  logic [AW-1:0] base_a, spare_off, start_ptr;
  logic [15:0]   tot_d;
  logic [7:0]    byte_v;

  assign is_cm   = op[3:2] == 2'b01;
  assign is_cw   = op[3:2] == 2'b10;
  assign is_cmd  = is_cm | is_cw;
  assign is_addr = op == 4'd1 || op == 4'd2 || op == 4'd3;
  assign is_wb   = op == 4'd12;
  assign is_rd   = op == 4'd13;
  assign nxt_op  = ins_q[slot[2:0]*4 +: 4];

  assign base_a    = large_pg ? (AW'(page[0]) << (UW + 2)) : (AW'(page[2:0]) << UW);
  assign spare_off = spare ? AW'(large_pg ? LP_MAIN : SP_MAIN) : '0;
  assign start_ptr = base_a + col[AW-1:0] + spare_off;
  assign tot_d     = (count == 16'd0) ? 16'(large_pg ? LP_MAIN + LP_SPARE : SP_MAIN + SP_SPARE) : count;

  always_comb begin
    byte_v = 8'h00;
    case (op)
      4'd1:    byte_v = bidx ? col_q[15:8] : col_q[7:0];
      4'd2:    byte_v = bidx ? page_q[15:8] : page_q[7:0];
      4'd3:    byte_v = col_q[7:0];
      4'd12:   byte_v = mem[ptr];
      default: if (is_cmd) byte_v = cmd_q[op[1:0]*8 +: 8];
    endcase
  end

  assign strobe_lo = st == S_XFER && tcnt != '0 && tcnt <= TW'(STRB);
  assign cap       = st == S_XFER && is_rd && tcnt == TW'(STRB);
  assign nf_ce_n   = !busy;
  assign nf_cle    = st == S_XFER && is_cmd;
  assign nf_ale    = st == S_XFER && is_addr;
  assign nf_we_n   = !(strobe_lo && !is_rd);
  assign nf_re_n   = !(strobe_lo && is_rd);
  assign nf_io_oe  = st == S_XFER && !is_rd;
  assign nf_io_out = byte_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; busy <= 1'b0; done_flag <= 1'b0; tmo_flag <= 1'b0;
      slot <= '0; op <= '0; ins_q <= '0; cmd_q <= '0; page_q <= '0; col_q <= '0;
      lp_q <= 1'b0; tot <= '0; nleft <= '0; bidx <= 1'b0; tcnt <= '0; wcnt <= '0; ptr <= '0;
    end else begin
      if (stat_clr[0]) done_flag <= 1'b0;
      if (stat_clr[1]) tmo_flag <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ins_q <= instr; cmd_q <= cmds; page_q <= page; col_q <= col; lp_q <= large_pg;
          tot <= tot_d; ptr <= start_ptr; slot <= '0; busy <= 1'b1; st <= S_FETCH;
        end
        S_FETCH: begin
          if (slot[3] || nxt_op == 4'd0 || nxt_op >= 4'd14) begin
            busy <= 1'b0; done_flag <= 1'b1; st <= S_IDLE;
          end else begin
            op <= nxt_op; slot <= slot + 4'd1; tcnt <= '0; bidx <= 1'b0; wcnt <= '0;
            if (nxt_op == 4'd12 || nxt_op == 4'd13) nleft <= tot;
            else if (nxt_op == 4'd2 || (nxt_op == 4'd1 && lp_q)) nleft <= 16'd2;
            else nleft <= 16'd1;
            st <= (nxt_op == 4'd13) ? S_WAIT : S_XFER;
          end
        end
        S_XFER: begin
          if (tcnt == TW'(STRB + 1)) begin
            tcnt <= '0; bidx <= 1'b1; nleft <= nleft - 16'd1;
            if (is_wb || is_rd) ptr <= ptr + AW'(1);
            if (nleft == 16'd1) begin
              wcnt <= '0;
              st <= is_cw ? S_WAIT : S_FETCH;
            end
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        S_WAIT: begin
          if (nf_rb_n) begin
            tcnt <= '0;
            st <= is_rd ? S_XFER : S_FETCH;
          end else if (wcnt == WW'(TMO - 1)) begin
            busy <= 1'b0; tmo_flag <= 1'b1; st <= S_IDLE;
          end else begin
            wcnt <= wcnt + WW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cap) mem[ptr] <= nf_io_in;
    else if (hb_we && !busy) mem[hb_addr] <= hb_wdata;
    hb_rdata <= mem[hb_addr];
  end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done_flag,
  input logic       tmo_flag,
  input logic       nf_ce_n,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic [7:0] nf_io_out
);
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));
  a_r3_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nf_we_n && nf_re_n && !nf_cle && !nf_ale));
  a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> $stable(nf_io_out));
  a_r8_flag_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_flag || tmo_flag));
  a_r2_cmd_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
    nf_cle |-> !nf_ce_n);
endmodule

bind nand_seq nand_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done_flag(done_flag), .tmo_flag(tmo_flag),
  .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
  .nf_re_n(nf_re_n), .nf_io_out(nf_io_out)
);

// File: tb/nand_seq_tb.sv
`timescale 1ns/1ps
module nand_seq_tb_top;
  localparam int STRB = 2;

  logic clk = 0, rst_n = 0, start = 0, spare = 0, large_pg = 0, hb_we = 0, nf_rb_n = 1;
  logic [31:0] instr = 0, cmds = 0;
  logic [15:0] page = 0, col = 0, count = 0;
  logic [1:0]  stat_clr = 0;
  logic [10:0] hb_addr = 0;
  logic [7:0]  hb_wdata = 0, hb_rdata, nf_io_out, nf_io_in;
  logic busy, done_flag, tmo_flag, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;

  int tests = 0, fails = 0;
  int nw = 0, ncle = 0, nale = 0, nre = 0, tim_err = 0, cc_seen = 0, wlow = 0, rlow = 0;
  logic prev_we = 1, prev_re = 1;
  logic [7:0] pre_io = 0, held_io = 0;
  logic [7:0] wlog [64];

  always #2 clk = ~clk;
  assign nf_io_in = 8'hC0 + nre[7:0];

  nand_seq dut_i (.*);

  typedef struct packed {
    logic [31:0] ins; logic [31:0] cmd; logic lp; logic [15:0] cnt;
    logic [7:0] we; logic [7:0] cl; logic [7:0] al; logic [15:0] re; logic [7:0] b0;
  } vec_t;
  localparam vec_t VEC [11] = '{
    '{32'h000D9218, 32'h00003000, 1'b1, 16'd8, 8'd6, 8'd2, 8'd4, 16'd8, 8'h00},
    '{32'h0000D218, 32'h00000050, 1'b0, 16'd4, 8'd4, 8'd1, 8'd3, 16'd4, 8'h50},
    '{32'h00000528, 32'h0000D060, 1'b1, 16'd0, 8'd4, 8'd2, 8'd2, 16'd0, 8'h60},
    '{32'h0009C218, 32'h00001080, 1'b1, 16'd3, 8'd9, 8'd2, 8'd4, 16'd0, 8'h80},
    '{32'h00000D38, 32'h00000090, 1'b0, 16'd5, 8'd2, 8'd1, 8'd1, 16'd5, 8'h90},
    '{32'h000000D4, 32'h00000070, 1'b0, 16'd1, 8'd1, 8'd1, 8'd0, 16'd1, 8'h70},
    '{32'h00000004, 32'h000000FF, 1'b0, 16'd1, 8'd1, 8'd1, 8'd0, 16'd0, 8'hFF},
    '{32'h00000208, 32'h00000011, 1'b0, 16'd1, 8'd1, 8'd1, 8'd0, 16'd0, 8'h11},
    '{32'h00000007, 32'hAB000000, 1'b0, 16'd1, 8'd1, 8'd1, 8'd0, 16'd0, 8'hAB},
    '{32'h44444444, 32'h00000012, 1'b0, 16'd1, 8'd8, 8'd8, 8'd0, 16'd0, 8'h12},
    '{32'h000004E4, 32'h00000033, 1'b0, 16'd1, 8'd1, 8'd1, 8'd0, 16'd0, 8'h33}
  };

  always @(negedge clk) begin
    if (prev_we && !nf_we_n) held_io = pre_io;
    if (!nf_we_n) wlow++;
    if (!prev_we && nf_we_n) begin
      if (wlow != STRB || nf_io_out !== held_io) tim_err++;
      wlog[nw[5:0]] = nf_io_out;
      if (nf_cle) ncle++;
      if (nf_ale) nale++;
      nw++; wlow = 0;
    end
    if (nf_we_n) pre_io = nf_io_out;
    if (!nf_re_n) rlow++;
    if (!prev_re && nf_re_n) begin
      if (rlow != STRB) tim_err++;
      nre++; rlow = 0;
    end
    if (done_flag) cc_seen++;
    prev_we = nf_we_n; prev_re = nf_re_n;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [31:0] i, input logic [31:0] c, input logic [15:0] pg,
                        input logic [15:0] cl, input logic sp, input logic lp, input logic [15:0] n);
    @(negedge clk);
    instr = i; cmds = c; page = pg; col = cl; spare = sp; large_pg = lp; count = n;
    stat_clr = 2'b11;
    @(negedge clk);
    stat_clr = 2'b00; nw = 0; ncle = 0; nale = 0; nre = 0; cc_seen = 0; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish_wait();
    while (busy) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] i, input logic [31:0] c, input logic [15:0] pg,
                     input logic [15:0] cl, input logic sp, input logic lp, input logic [15:0] n);
    launch(i, c, pg, cl, sp, lp, n);
    finish_wait();
  endtask

  task automatic hwrite(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); hb_addr = a; hb_wdata = d; hb_we = 1;
    @(negedge clk); hb_we = 0;
  endtask

  task automatic hread(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk); hb_addr = a;
    @(negedge clk); d = hb_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R12 busy", busy, 0);
    check("R12 flags", {done_flag, tmo_flag}, 0);
    check("R12 strobes", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 5'b11100);
    rst_n = 1;

    for (int k = 0; k < 11; k++) begin
      run(VEC[k].ins, VEC[k].cmd, 16'h0000, 16'h0000, 1'b0, VEC[k].lp, VEC[k].cnt);
      check("R1 write cycles", nw, VEC[k].we);
      check("R2 cle cycles", ncle, VEC[k].cl);
      check("R3 ale cycles", nale, VEC[k].al);
      check("R6 read cycles", nre, VEC[k].re);
      check("R2 first byte", wlog[0], VEC[k].b0);
      check("R8 done set", {done_flag, tmo_flag, busy}, 3'b100);
    end

    run(32'h000D9218, 32'h00003000, 16'h4567, 16'h0123, 1'b0, 1'b1, 16'd1);
    check("R3 large col lo", wlog[1], 8'h23);
    check("R3 large col hi", wlog[2], 8'h01);
    check("R3 page lo", wlog[3], 8'h67);
    check("R3 page hi", wlog[4], 8'h45);
    run(32'h0000D218, 32'h0, 16'h0102, 16'h0045, 1'b0, 1'b0, 16'd1);
    check("R3 small col", wlog[1], 8'h45);
    check("R3 small page", {wlog[2], wlog[3]}, 16'h0201);
    run(32'h00000D38, 32'h90, 16'h0, 16'h0077, 1'b0, 1'b0, 16'd5);
    check("R3 single addr", wlog[1], 8'h77);

    run(32'h0000D218, 32'h0, 16'd5, 16'd3, 1'b0, 1'b0, 16'd4);
    for (int k = 0; k < 4; k++) begin
      hread(11'(1283 + k), d);
      check("R5 small buffer place", d, 8'hC0 + 8'(k));
    end
    run(32'h000D9218, 32'h3000, 16'd3, 16'd2, 1'b1, 1'b1, 16'd2);
    hread(11'd1538, d); check("R5 large spare place", d, 8'hC0);
    hread(11'd1539, d); check("R11 host read", d, 8'hC1);

    hwrite(11'd1536, 8'h11); hwrite(11'd1537, 8'h22); hwrite(11'd1538, 8'h33);
    run(32'h0009C218, 32'h1080, 16'd6, 16'd0, 1'b0, 1'b0, 16'd3);
    check("R6 write data", {wlog[4], wlog[5], wlog[6]}, 24'h112233);
    check("R6 data no latch", {ncle, nale}, {32'd2, 32'd3});

    run(32'h0000D218, 32'h0, 16'd0, 16'd0, 1'b0, 1'b0, 16'd0);
    check("R4 small full", nre, 144);

    nf_rb_n = 0;
    run(32'h00000908, 32'h3000, 16'd0, 16'd0, 1'b0, 1'b0, 16'd1);
    check("R8 timeout flags", {done_flag, tmo_flag}, 2'b01);
    check("R2 wait blocks next", nw, 1);
    run(32'h00000054, 32'h3000, 16'd0, 16'd0, 1'b0, 1'b0, 16'd1);
    check("R2 no wait", {done_flag, tmo_flag, nw[7:0]}, {2'b10, 8'd2});

    launch(32'h000000D4, 32'h70, 16'd0, 16'd0, 1'b0, 1'b0, 16'd1);
    repeat (20) @(negedge clk);
    check("R6 read waits ready", nre, 0);
    nf_rb_n = 1;
    finish_wait();
    check("R6 read after ready", nre, 1);

    hwrite(11'd2000, 8'h55);
    launch(32'h000D9218, 32'h3000, 16'd0, 16'd0, 1'b0, 1'b1, 16'd0);
    repeat (30) @(negedge clk);
    instr = 32'h00000004; start = 1; hb_addr = 11'd2000; hb_wdata = 8'h99; hb_we = 1;
    @(negedge clk);
    start = 0; hb_we = 0;
    finish_wait();
    check("R4 large full", nre, 576);
    check("R10 start ignored", ncle, 2);
    hread(11'd2000, d);
    check("R11 busy write ignored", d, 8'h55);

    check("R9 before clear", done_flag, 1);
    @(negedge clk); stat_clr = 2'b10;
    @(negedge clk); stat_clr = 2'b00;
    check("R9 other bit keeps", done_flag, 1);
    @(negedge clk); stat_clr = 2'b01;
    @(negedge clk); stat_clr = 2'b00;
    check("R9 w1c", done_flag, 0);

    launch(32'h00000004, 32'hFF, 16'd0, 16'd0, 1'b0, 1'b0, 16'd1);
    stat_clr = 2'b01;
    finish_wait();
    @(negedge clk);
    stat_clr = 2'b00;
    check("R9 set beats clear", cc_seen, 1);
    check("R9 cleared after", done_flag, 0);

    check("R7 strobe timing", tim_err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule